// File: doc/BRIEF.md
# Low-Speed HID Wake Hold Monitor

This block keeps a low-speed keyboard or mouse attached while the host puts a USB charging port to sleep. It watches a digitized D− level, the mode the port is actually running in, and the 4-bit charging code the host is requesting. If a low-speed device was seen during a data-capable mode (SDP1, SDP2 or CDP), a later host request for automatic dedicated charging is overridden. The block raises a hold that tells the mode logic to leave the data path in its SDP/CDP configuration.

While the hold is active, a low pulse on D− means the device is active and wants to wake the host. That pulse starts a wake window counted in 1 ms ticks, 64 ticks by default. If the host puts the SDP/CDP code back before the window closes, the hold drops and the attach record is kept. If the request still reads automatic charging when the window closes, the block emits a one-cycle expiry pulse. In that same cycle it drops the hold and forgets the attach, so the port moves to automatic charging and the device is disconnected. Detecting full-speed devices and the analog comparators is done elsewhere.

Top module: `hid_wake_hold`

## Requirements
- R1: After reset, hold_o and expire_o are 0.
- R2: An attach is recorded only after dm_hi_i has been high for ATTACH_TICKS (2) consecutive ticks while mode_i is SDP1 (2'b01), SDP2 (2'b10) or CDP (2'b11). A break in that run restarts the count.
- R3: With mode_i equal to 2'b00 (any non-SDP/CDP mode), dm_hi_i is ignored and no attach is recorded.
- R4: With an attach recorded and en_i high, hold_o is 1 in the same cycle that req_code_i reads automatic charging, i.e. req_code_i[3:1] == 3'b011 (bit 0 is don't-care).
- R5: While holding, dm_hi_i low at a clock edge starts the wake window. If the request is still automatic on the WAKE_TICKS-th (64th) tick after that, expire_o pulses high for exactly one cycle, and hold_o is 0 from that cycle on.
- R6: If req_code_i leaves the automatic code during the window, hold_o drops at once and no expiry occurs. The attach stays recorded, so a new automatic request raises hold_o again without a new attach.
- R7: If the attach is recorded, no hold is active, and mode_i becomes 2'b00, the attach is cleared.
- R8: en_i low forces hold_o to 0 at once and clears the attach and the wake window.
- R9: The wake window advances only on tick_ms_i. After WAKE_TICKS−1 ticks there is no expiry yet.
- R10: After an expiry the attach is cleared, so an automatic request that continues raises no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Port enable; low clears all monitor state |
| dm_hi_i | input | 1 | Digitized D− level, 1 = pulled high |
| mode_i | input | 2 | Running mode: 00 other, 01 SDP1, 10 SDP2, 11 CDP |
| req_code_i | input | 4 | Requested charging code; [3:1]=011 means automatic charging |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| hold_o | output | 1 | Keep data path in SDP/CDP |
| expire_o | output | 1 | One-cycle pulse when the wake window closes and the hold is released |

## Verification
A wrong internal state shows up in one of two ways. A lost attach shows as hold_o staying 0 in the same cycle the automatic code is requested. A stale attach shows as hold_o rising when no device has been seen. A wake counter that is off by one is visible only at the closing tick: expire_o arrives one tick early or late, so the bench checks both the 63rd and the 64th tick. A record that survives a mode change, a disable or an expiry is caught by a fresh automatic request made within a few cycles of the event.

// File: rtl/hid_wake_pkg.sv
package hid_wake_pkg;
  typedef enum logic [1:0] {
    MODE_OTHER = 2'b00,
    MODE_SDP1  = 2'b01,
    MODE_SDP2  = 2'b10,
    MODE_CDP   = 2'b11
  } port_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_HOLD,
    ST_COUNT
  } mon_state_e;

  // code bit 3..1 = 011 selects automatic charging, bit 0 don't-care
  function automatic logic is_auto_req(input logic [3:0] code);
    return code[3:1] == 3'b011;
  endfunction
endpackage

// File: rtl/hid_tick_cnt.sv
module hid_tick_cnt #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/hid_hold_fsm.sv
module hid_hold_fsm
  import hid_wake_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       dm_hi_i,
  input  logic [1:0] mode_i,
  input  logic       req_auto_i,
  input  logic       att_done_i,
  input  logic       wake_done_i,
  output logic       att_run_o,
  output logic       wake_run_o,
  output logic       wake_clr_o,
  output logic       hold_o,
  output logic       expire_o
);
  mon_state_e state_q, state_d;
  logic       exp_q, exp_d;
  logic       data_mode;

  assign data_mode  = port_mode_e'(mode_i) != MODE_OTHER;
  assign att_run_o  = en_i && (state_q == ST_IDLE) && data_mode && dm_hi_i;
  assign wake_run_o = en_i && (state_q == ST_COUNT);
  assign wake_clr_o = state_q != ST_COUNT;
  assign hold_o     = en_i && req_auto_i && (state_q != ST_IDLE);
  assign expire_o   = exp_q;

  always_comb begin
    state_d = state_q;
    exp_d   = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (att_done_i) state_d = ST_ARMED;
        ST_ARMED: begin
          if (req_auto_i)     state_d = ST_HOLD;
          else if (!data_mode) state_d = ST_IDLE;
        end
        ST_HOLD: begin
          if (!req_auto_i)    state_d = ST_ARMED;
          else if (!dm_hi_i)  state_d = ST_COUNT;
        end
        ST_COUNT: begin
          if (!req_auto_i) begin
            state_d = ST_ARMED;
          end else if (wake_done_i) begin
            state_d = ST_IDLE;
            exp_d   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      exp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exp_q   <= exp_d;
    end
  end
endmodule

// File: rtl/hid_wake_hold.sv
module hid_wake_hold #(
  parameter int ATTACH_TICKS = 2,
  parameter int WAKE_TICKS   = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       dm_hi_i,
  input  logic [1:0] mode_i,
  input  logic [3:0] req_code_i,
  input  logic       tick_ms_i,
  output logic       hold_o,
  output logic       expire_o
);
  logic req_auto, att_run, att_done, wake_run, wake_clr, wake_done;

  assign req_auto = hid_wake_pkg::is_auto_req(req_code_i);

  hid_tick_cnt #(.LIMIT(ATTACH_TICKS)) u_att_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!att_run),
    .run_i  (att_run),
    .tick_i (tick_ms_i),
    .done_o (att_done)
  );

  hid_tick_cnt #(.LIMIT(WAKE_TICKS)) u_wake_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wake_clr),
    .run_i  (wake_run),
    .tick_i (tick_ms_i),
    .done_o (wake_done)
  );

  hid_hold_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .dm_hi_i     (dm_hi_i),
    .mode_i      (mode_i),
    .req_auto_i  (req_auto),
    .att_done_i  (att_done),
    .wake_done_i (wake_done),
    .att_run_o   (att_run),
    .wake_run_o  (wake_run),
    .wake_clr_o  (wake_clr),
    .hold_o      (hold_o),
    .expire_o    (expire_o)
  );
endmodule

// File: rtl/hid_wake_hold_chk.sv
module hid_wake_hold_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [3:0] req_code_i,
  input logic       tick_ms_i,
  input logic       hold_o,
  input logic       expire_o
);
  logic req_auto;
  assign req_auto = req_code_i[3:1] == 3'b011;

  a_r5_expire_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

  a_r5_expire_drops_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !hold_o);

  a_r5_expire_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(hold_o) && $past(req_auto));

  a_r9_expire_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(tick_ms_i));

  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hold_o && !expire_o);
endmodule

bind hid_wake_hold hid_wake_hold_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .req_code_i (req_code_i),
  .tick_ms_i  (tick_ms_i),
  .hold_o     (hold_o),
  .expire_o   (expire_o)
);

// File: tb/tb_hid_wake_hold.sv
`timescale 1ns/1ps
module tb_hid_wake_hold;
  logic clk = 0, rst_n = 0, en = 1, dm = 0, tick = 0;
  logic [1:0] mode = 2'b00;
  logic [3:0] req = 4'b0000;
  logic hold, expire;
  int checks = 0, errors = 0;

  localparam logic [3:0] AUTO = 4'b0110, CDPC = 4'b1111, SDP2C = 4'b1110;

  always #10 clk = ~clk;

  hid_wake_hold dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dm_hi_i(dm), .mode_i(mode),
    .req_code_i(req), .tick_ms_i(tick), .hold_o(hold), .expire_o(expire)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    #1;
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 0; en = 1; dm = 0; tick = 0; mode = 2'b00; req = 4'b0000;
    @(negedge clk) rst_n = 1;
    #1;
  endtask

  task automatic attach(input logic [1:0] m, input logic [3:0] code);
    @(negedge clk) mode = m; req = code; dm = 1;
    do_tick(); do_tick();
  endtask

  task automatic start_window();
    @(negedge clk) dm = 0;
    @(negedge clk) dm = 1;
    #1;
  endtask

  task automatic t_reset();
    restart();
    chk("R1 hold after reset", hold, 1'b0);
    chk("R1 expire after reset", expire, 1'b0);
  endtask

  task automatic t_short_attach();
    restart();
    @(negedge clk) mode = 2'b01; dm = 1;
    do_tick();
    @(negedge clk) dm = 0;
    do_tick();
    @(negedge clk) dm = 1;
    do_tick();
    @(negedge clk) req = AUTO; #1;
    chk("R2 broken attach run no hold", hold, 1'b0);
    @(negedge clk) req = CDPC;
    do_tick();
    @(negedge clk) req = AUTO; #1;
    chk("R2 two ticks attach holds", hold, 1'b1);
  endtask

  task automatic t_other_mode();
    restart();
    attach(2'b00, CDPC);
    do_tick(); do_tick();
    @(negedge clk) req = AUTO; #1;
    chk("R3 other mode no attach", hold, 1'b0);
  endtask

  task automatic t_expire();
    restart();
    attach(2'b11, CDPC);
    @(negedge clk) req = AUTO; #1;
    chk("R4 hold same cycle", hold, 1'b1);
    @(negedge clk) req = 4'b0111; #1;
    chk("R4 bit0 dont care", hold, 1'b1);
    start_window();
    for (int i = 0; i < 63; i++) do_tick();
    chk("R9 no expire at 63", expire, 1'b0);
    chk("R9 hold at 63", hold, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 no count without tick", expire, 1'b0);
    do_tick();
    chk("R5 expire at 64", expire, 1'b1);
    chk("R5 hold dropped", hold, 1'b0);
    @(negedge clk) #1;
    chk("R5 expire one cycle", expire, 1'b0);
    repeat (4) @(negedge clk);
    #1;
    chk("R10 no hold after expire", hold, 1'b0);
  endtask

  task automatic t_restore();
    restart();
    attach(2'b10, SDP2C);
    @(negedge clk) req = AUTO;
    start_window();
    for (int i = 0; i < 10; i++) do_tick();
    @(negedge clk) req = SDP2C; #1;
    chk("R6 restore drops hold", hold, 1'b0);
    for (int i = 0; i < 70; i++) begin
      do_tick();
      if (expire) chk("R6 no expire after restore", expire, 1'b0);
    end
    chk("R6 no expire after restore", expire, 1'b0);
    @(negedge clk) dm = 0; req = AUTO; #1;
    chk("R6 attach kept", hold, 1'b1);
  endtask

  task automatic t_mode_clear();
    restart();
    attach(2'b01, 4'b0100);
    @(negedge clk) mode = 2'b00; dm = 0;
    @(negedge clk) req = AUTO; #1;
    chk("R7 mode exit clears attach", hold, 1'b0);
  endtask

  task automatic t_enable_low();
    restart();
    attach(2'b11, CDPC);
    @(negedge clk) req = AUTO;
    start_window();
    for (int i = 0; i < 20; i++) do_tick();
    @(negedge clk) en = 0; #1;
    chk("R8 en low drops hold", hold, 1'b0);
    @(negedge clk) en = 1; dm = 0; #1;
    chk("R8 attach cleared", hold, 1'b0);
    for (int i = 0; i < 70; i++) do_tick();
    chk("R8 window cleared", expire, 1'b0);
    chk("R8 still no hold", hold, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_short_attach();
    t_other_mode();
    t_expire();
    t_restore();
    t_mode_clear();
    t_enable_low();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule